// File: doc/BRIEF.md
# Multi-Variant System Control Register Block

This block is a 32-bit register file for system control, mapped into memory. It sits on a simple request bus with a valid strobe, a write flag, a byte address and write data. The static parameter `VARIANT` builds it as one of three hardware flavours:

- basic (0)
- dual-core (1)
- single-core with power lock (2)

The flavour decides which offsets exist, which are read-only and which are remapped. The block holds these registers:

- the boot vectors
- the CPU hold-off (wait) bits
- the NMI enable
- the clock divider and clock force settings
- a security control word
- a power-control word
- the power-domain sense words
- a read-only identification window

From this state it drives two outputs. The boot vector outputs go to the cores. The one-cycle release pulses go to the reset sequencer and tell a core to power up and leave reset.

Every request gets a response one clock later. The response carries the read data and an error flag. The error flag is set for an offset that does not exist in the built variant, for a write to a read-only location, and for a write that a lock refuses. In the single-core variant two registers protect themselves. The boot vector locks itself once its lock bit is written. The power-control word accepts writes only while its own unlock bit is set.

Top module: `sysctl_regblk`

## Requirements
- R1: After reset the registers hold these values: boot vector 0 = `BOOT0_RST` (default 0x1000_0000), CPU-wait = `WAIT_RST`, power control (0x1FC) = 0x3, system sense (0x200) = 0x7F. Every other register, including NMI enable and boot vector 1, reads 0. `resp_valid` and `cpu_release` are low.
- R2: A request sampled on a clock edge produces `resp_valid` high for exactly the following cycle. `resp_rdata` and `resp_err` are valid in that same cycle. A write response carries `resp_rdata` = 0.
- R3: An access to an offset that is not word-aligned (address bits 1:0 not 00) or not mapped in the built variant returns data 0 with `resp_err` = 1. Such a write changes no register.
- R4: In the basic variant, offset 0x11C reads 0 without error. A write to 0x11C, or to any identification offset 0xFD0..0xFFC, is ignored and returns `resp_err` = 1.
- R5: The identification window returns one byte per word, in offset order from 0xFD0: 04,00,00,00, 54,B8,xx,00, 0D,F0,05,B1. The byte xx is 0B in the basic variant and 1B in the other two.
- R6: In the basic and dual-core variants, all 32 bits of boot vector 0 (0x110) appear on `boot_vec0`.
- R7: In the single-core variant, bit 0 of boot vector 0 is a lock. Once it reads 1, every write to 0x110 is dropped with `resp_err` = 1. `boot_vec0` shows only bits 31:7, with bits 6:0 forced to 0. A read of 0x110 returns the full stored word.
- R8: In the single-core variant, a write to power control (0x1FC) is stored only while the stored bit 0 (unlock) is 1. Otherwise the write is dropped with `resp_err` = 1. In the other variants 0x1FC is unmapped.
- R9: A write to CPU-wait that moves bit i from 1 to 0 raises `cpu_release[i]` for exactly one cycle, in the response cycle. Bits 0 and 1 are watched in the basic and dual-core variants; only bit 0 is watched in the single-core variant.
- R10: The single-core map differs from the dual-core map:
  - CPU-wait moves to 0x120 and NMI enable to 0x124.
  - 0x114, 0x118, 0x11C, 0x20C and 0x210 are unmapped.
  - 0x204 holds the CPU sense word.
  - 0x214 and 0x218 hold the two memory-region sense words.
- R11: The dual-core variant maps these registers:
  - boot vector 1 at 0x114, driving `boot_vec1`
  - CPU-wait at 0x118
  - NMI enable at 0x11C
  - an early-wake control word at 0x124
  - sense words at 0x20C, 0x210, 0x214 and 0x218

  In the other variants `boot_vec1` is 0.
- R12: The basic variant leaves these offsets unmapped: security control 0x000, fast clock divider 0x004, system clock divider 0x008, clock force 0x00C, and every sense and power offset. The other two variants store 0x000..0x00C as plain read/write words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_err | output | 1 | Error for the response: unmapped offset, read-only write or locked write |
| resp_rdata | output | DATA_W | Read data, 0 on error and on writes |
| cpu_release | output | MAX_CPUS | One-cycle power-on-and-reset request per CPU |
| boot_vec0 | output | DATA_W | Boot vector for CPU 0 |
| boot_vec1 | output | DATA_W | Boot vector for CPU 1 (dual-core variant only) |

## Verification
All results come one register stage after the request edge:
- read data and the error flag
- the response strobe
- the release pulses
- the updated boot vector outputs

The bench drives a request on a falling edge. It samples everything on the next falling edge, which is exactly one rising edge later. For the strobe and the pulses it also samples the falling edge after that, to confirm they have dropped. Effects a write could have had, including ignored writes, are checked by a read-back request on the following cycle. The three variants are built side by side on one shared bus, so each access is checked against all three maps at once.

// File: rtl/sysctl_pkg.sv
// Shared constants, types and helpers for the system control register block.
// Assumes a 32-bit data path and a byte address of at least 12 bits.
package sysctl_pkg;

    // Variant selectors
    localparam int VAR_BASIC  = 0;
    localparam int VAR_DUAL   = 1;
    localparam int VAR_SINGLE = 2;

    localparam int MAX_CPUS = 2;

    // Register offsets (byte addresses)
    localparam logic [11:0] OFF_SEC      = 12'h000;
    localparam logic [11:0] OFF_FDIV     = 12'h004;
    localparam logic [11:0] OFF_SDIV     = 12'h008;
    localparam logic [11:0] OFF_CFRC     = 12'h00C;
    localparam logic [11:0] OFF_BOOT0    = 12'h110;
    localparam logic [11:0] OFF_BOOT1    = 12'h114;
    localparam logic [11:0] OFF_WAIT_A   = 12'h118;
    localparam logic [11:0] OFF_NMI_A    = 12'h11C;
    localparam logic [11:0] OFF_WAIT_B   = 12'h120;
    localparam logic [11:0] OFF_NMI_B    = 12'h124;
    localparam logic [11:0] OFF_PWR      = 12'h1FC;
    localparam logic [11:0] OFF_SNS_SYS  = 12'h200;
    localparam logic [11:0] OFF_SNS_CPU0 = 12'h204;
    localparam logic [11:0] OFF_SNS_M0   = 12'h20C;
    localparam logic [11:0] OFF_SNS_M1   = 12'h210;
    localparam logic [11:0] OFF_SNS_X0   = 12'h214;
    localparam logic [11:0] OFF_SNS_X1   = 12'h218;
    localparam logic [11:0] OFF_ID_LO    = 12'hFD0;
    localparam logic [11:0] OFF_ID_HI    = 12'hFFC;

    // Field positions
    localparam int BOOT_LOCK_BIT  = 0;
    localparam int BOOT_VEC_LSB   = 7;
    localparam int PWR_UNLOCK_BIT = 0;

    // Reset values of fixed registers
    localparam logic [31:0] PWR_RST     = 32'h0000_0003;
    localparam logic [31:0] SNS_SYS_RST = 32'h0000_007F;

    // Storage slots, one per physical register
    typedef enum logic [3:0] {
        SL_SECCTL, SL_FDIV,     SL_SDIV,   SL_CFORCE,
        SL_BOOT0,  SL_BOOT1,    SL_WAIT,   SL_NMI,
        SL_EWCTL,  SL_PWR,      SL_SNS_SYS, SL_SNS_CPU0,
        SL_SNS_M0, SL_SNS_M1,   SL_SNS_X0, SL_SNS_X1
    } slot_e;

    localparam int NUM_SLOTS = 16;

    // Access class of a decoded offset
    typedef enum logic [1:0] {
        AK_INVALID,
        AK_RW,
        AK_RO_ZERO,
        AK_RO_ID
    } kind_e;

    // Identification byte for word index 0..11 of the ID window
    function automatic logic [7:0] id_byte(input int variant, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h54;
            4'd5:    b = 8'hB8;
            4'd6:    b = (variant == VAR_BASIC) ? 8'h0B : 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sysctl_addr_map.sv
// Address decoder: turns a byte offset into an access class, a storage slot and,
// for the identification window, the byte to return. Purely combinational.
// Assumes ADDR_W >= 12; the variant is fixed at build time.
module sysctl_addr_map
    import sysctl_pkg::*;
#(
    parameter int VARIANT = VAR_DUAL,
    parameter int ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output kind_e             kind,
    output slot_e             slot,
    output logic [7:0]        id_val
);
    localparam bit IS_BASIC  = (VARIANT == VAR_BASIC);
    localparam bit IS_DUAL   = (VARIANT == VAR_DUAL);
    localparam bit IS_SINGLE = (VARIANT == VAR_SINGLE);

    logic [ADDR_W-1:0] id_off;
    logic [3:0]        id_idx;

    // Word index inside the identification window
    always_comb begin
        id_off = addr - ADDR_W'(OFF_ID_LO);
        id_idx = 4'(id_off >> 2);
    end

    // Per-variant offset map
    always_comb begin
        kind   = AK_INVALID;
        slot   = SL_SECCTL;
        id_val = 8'h00;
        if (addr[1:0] == 2'b00) begin
            case (addr)
                ADDR_W'(OFF_SEC):      if (!IS_BASIC) begin kind = AK_RW; slot = SL_SECCTL; end
                ADDR_W'(OFF_FDIV):     if (!IS_BASIC) begin kind = AK_RW; slot = SL_FDIV; end
                ADDR_W'(OFF_SDIV):     if (!IS_BASIC) begin kind = AK_RW; slot = SL_SDIV; end
                ADDR_W'(OFF_CFRC):     if (!IS_BASIC) begin kind = AK_RW; slot = SL_CFORCE; end
                ADDR_W'(OFF_BOOT0):    begin kind = AK_RW; slot = SL_BOOT0; end
                ADDR_W'(OFF_BOOT1):    if (IS_DUAL) begin kind = AK_RW; slot = SL_BOOT1; end
                ADDR_W'(OFF_WAIT_A):   if (!IS_SINGLE) begin kind = AK_RW; slot = SL_WAIT; end
                ADDR_W'(OFF_NMI_A): begin
                    if (IS_BASIC) begin
                        kind = AK_RO_ZERO;
                    end else if (IS_DUAL) begin
                        kind = AK_RW;
                        slot = SL_NMI;
                    end
                end
                ADDR_W'(OFF_WAIT_B):   if (IS_SINGLE) begin kind = AK_RW; slot = SL_WAIT; end
                ADDR_W'(OFF_NMI_B): begin
                    if (IS_SINGLE) begin
                        kind = AK_RW;
                        slot = SL_NMI;
                    end else if (IS_DUAL) begin
                        kind = AK_RW;
                        slot = SL_EWCTL;
                    end
                end
                ADDR_W'(OFF_PWR):      if (IS_SINGLE) begin kind = AK_RW; slot = SL_PWR; end
                ADDR_W'(OFF_SNS_SYS):  if (!IS_BASIC) begin kind = AK_RW; slot = SL_SNS_SYS; end
                ADDR_W'(OFF_SNS_CPU0): if (IS_SINGLE) begin kind = AK_RW; slot = SL_SNS_CPU0; end
                ADDR_W'(OFF_SNS_M0):   if (IS_DUAL) begin kind = AK_RW; slot = SL_SNS_M0; end
                ADDR_W'(OFF_SNS_M1):   if (IS_DUAL) begin kind = AK_RW; slot = SL_SNS_M1; end
                ADDR_W'(OFF_SNS_X0):   if (!IS_BASIC) begin kind = AK_RW; slot = SL_SNS_X0; end
                ADDR_W'(OFF_SNS_X1):   if (!IS_BASIC) begin kind = AK_RW; slot = SL_SNS_X1; end
                default: begin
                    if (addr >= ADDR_W'(OFF_ID_LO) && addr <= ADDR_W'(OFF_ID_HI)) begin
                        kind   = AK_RO_ID;
                        id_val = id_byte(VARIANT, id_idx);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sysctl_reg_store.sv
// Register storage: one word per slot, with the write locks of the single-core variant.
// Assumes wr_en is already qualified as a write to a read/write offset.
// A dropped write is reported combinationally on wr_drop.
module sysctl_reg_store
    import sysctl_pkg::*;
#(
    parameter int          VARIANT   = VAR_DUAL,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] BOOT0_RST = 32'h1000_0000,
    parameter logic [31:0] WAIT_RST  = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_e             wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_drop,
    output logic [DATA_W-1:0] slot_q [NUM_SLOTS]
);
    localparam bit IS_SINGLE = (VARIANT == VAR_SINGLE);

    // Reset value of a slot
    function automatic logic [DATA_W-1:0] rst_of(input int s);
        logic [DATA_W-1:0] v;
        case (s)
            int'(SL_BOOT0):   v = DATA_W'(BOOT0_RST);
            int'(SL_WAIT):    v = DATA_W'(WAIT_RST);
            int'(SL_PWR):     v = DATA_W'(PWR_RST);
            int'(SL_SNS_SYS): v = DATA_W'(SNS_SYS_RST);
            default:          v = '0;
        endcase
        return v;
    endfunction

    logic commit;

    // Lock gating: locked boot vector (single-core) or cleared power unlock bit
    always_comb begin
        wr_drop = wr_en &&
                  ((IS_SINGLE && wr_slot == SL_BOOT0 && slot_q[SL_BOOT0][BOOT_LOCK_BIT]) ||
                   (wr_slot == SL_PWR && !slot_q[SL_PWR][PWR_UNLOCK_BIT]));
        commit  = wr_en && !wr_drop;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Storage word for slot g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= rst_of(g);
            end else if (commit && wr_slot == slot_e'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    // The boot lock, once set, freezes the whole word (R7)
    if (IS_SINGLE) begin : g_lock_chk
        p_boot_lock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            slot_q[SL_BOOT0][BOOT_LOCK_BIT] |=> $stable(slot_q[SL_BOOT0]))
            else $error("boot vector changed while locked");
    end

    // A cleared unlock bit freezes the power word (R8)
    p_pwr_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_q[SL_PWR][PWR_UNLOCK_BIT] |=> $stable(slot_q[SL_PWR]))
        else $error("power control changed while locked");

endmodule

// File: rtl/sysctl_release_gen.sv
// CPU release pulse generator: a registered one-cycle pulse per watched CPU
// when its wait bit goes from 1 to 0 on a committed write.
// The variant sets how many CPUs are watched; the others stay low.
module sysctl_release_gen
    import sysctl_pkg::*;
#(
    parameter int VARIANT = VAR_DUAL,
    parameter int NCPU_W  = MAX_CPUS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_wr,
    input  logic [NCPU_W-1:0] wait_old,
    input  logic [NCPU_W-1:0] wait_new,
    output logic [NCPU_W-1:0] release_o
);
    localparam int NCPU = (VARIANT == VAR_SINGLE) ? 1 : NCPU_W;

    for (genvar g = 0; g < NCPU_W; g++) begin : g_cpu
        if (g < NCPU) begin : g_live
            // Falling-edge detect on wait bit g
            always_ff @(posedge clk) begin
                if (!rst_n) release_o[g] <= 1'b0;
                else        release_o[g] <= wait_wr && wait_old[g] && !wait_new[g];
            end

            p_release_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
                release_o[g] |-> $past(wait_wr))
                else $error("release pulse without a wait write");

            p_release_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
                release_o[g] |=> !release_o[g])
                else $error("release pulse longer than one cycle");
        end else begin : g_idle
            assign release_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/sysctl_regblk.sv
// System control register block, top level. Decodes a one-access-per-cycle
// request bus, applies reads and writes to the register store, and returns
// a registered response one cycle later. It also drives the boot vectors and
// the CPU release pulses. VARIANT is fixed at build time.
module sysctl_regblk
    import sysctl_pkg::*;
#(
    parameter int          VARIANT   = VAR_DUAL,
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] BOOT0_RST = 32'h1000_0000,
    parameter logic [31:0] WAIT_RST  = 32'h0000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                resp_valid,
    output logic                resp_err,
    output logic [DATA_W-1:0]   resp_rdata,
    output logic [MAX_CPUS-1:0] cpu_release,
    output logic [DATA_W-1:0]   boot_vec0,
    output logic [DATA_W-1:0]   boot_vec1
);
    localparam bit                IS_SINGLE = (VARIANT == VAR_SINGLE);
    localparam bit                IS_DUAL   = (VARIANT == VAR_DUAL);
    localparam logic [DATA_W-1:0] VEC_MASK  = ~((DATA_W'(1) << BOOT_VEC_LSB) - DATA_W'(1));

    kind_e             dec_kind;
    slot_e             dec_slot;
    logic [7:0]        dec_id;
    logic              st_wr;
    logic              st_drop;
    logic [DATA_W-1:0] slot_q [NUM_SLOTS];
    logic [DATA_W-1:0] rd_next;
    logic              err_next;
    logic              wait_wr;

    sysctl_addr_map #(
        .VARIANT (VARIANT),
        .ADDR_W  (ADDR_W)
    ) u_map (
        .addr   (req_addr),
        .kind   (dec_kind),
        .slot   (dec_slot),
        .id_val (dec_id)
    );

    // Qualify writes that reach storage
    always_comb begin
        st_wr   = req_valid && req_write && (dec_kind == AK_RW);
        wait_wr = st_wr && (dec_slot == SL_WAIT);
    end

    sysctl_reg_store #(
        .VARIANT   (VARIANT),
        .DATA_W    (DATA_W),
        .BOOT0_RST (BOOT0_RST),
        .WAIT_RST  (WAIT_RST)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr),
        .wr_slot (dec_slot),
        .wr_data (req_wdata),
        .wr_drop (st_drop),
        .slot_q  (slot_q)
    );

    sysctl_release_gen #(
        .VARIANT (VARIANT),
        .NCPU_W  (MAX_CPUS)
    ) u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_wr   (wait_wr),
        .wait_old  (slot_q[SL_WAIT][MAX_CPUS-1:0]),
        .wait_new  (req_wdata[MAX_CPUS-1:0]),
        .release_o (cpu_release)
    );

    // Next response data and error, by access class
    always_comb begin
        rd_next  = '0;
        err_next = 1'b0;
        unique case (dec_kind)
            AK_RW: begin
                if (!req_write) rd_next = slot_q[dec_slot];
                err_next = st_drop;
            end
            AK_RO_ZERO: err_next = req_write;
            AK_RO_ID: begin
                if (req_write) err_next = 1'b1;
                else           rd_next  = DATA_W'(dec_id);
            end
            default: err_next = 1'b1;
        endcase
    end

    // Response register: one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_err   <= req_valid && err_next;
            resp_rdata <= (req_valid && !err_next) ? rd_next : '0;
        end
    end

    // Boot vector outputs
    always_comb begin
        boot_vec0 = IS_SINGLE ? (slot_q[SL_BOOT0] & VEC_MASK) : slot_q[SL_BOOT0];
        boot_vec1 = IS_DUAL ? slot_q[SL_BOOT1] : '0;
    end

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid)
        else $error("missing response");

    p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid)
        else $error("response without request");

    p_err_data_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (resp_rdata == '0))
        else $error("error response carries data");

    p_err_needs_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_valid)
        else $error("error flag without response");

endmodule

// File: tb/sysctl_regblk_test.sv
// Directed bench: the three variants share one request bus.
// Index 0 = basic, 1 = dual-core (uut), 2 = single-core.
module sysctl_regblk_test;
    import sysctl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;

    logic [31:0] o_rdata [3];
    logic        o_err   [3];
    logic        o_rv    [3];
    logic [1:0]  o_rel   [3];
    logic [31:0] o_v0    [3];
    logic [31:0] o_v1    [3];

    logic [31:0] c_rdata [3];
    logic        c_err   [3];
    logic        c_rv    [3];
    logic [1:0]  c_rel   [3];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sysctl_regblk #(.VARIANT(VAR_BASIC)) uut_b (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(o_rv[0]),
        .resp_err(o_err[0]), .resp_rdata(o_rdata[0]), .cpu_release(o_rel[0]),
        .boot_vec0(o_v0[0]), .boot_vec1(o_v1[0]));

    sysctl_regblk #(.VARIANT(VAR_DUAL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(o_rv[1]),
        .resp_err(o_err[1]), .resp_rdata(o_rdata[1]), .cpu_release(o_rel[1]),
        .boot_vec0(o_v0[1]), .boot_vec1(o_v1[1]));

    sysctl_regblk #(.VARIANT(VAR_SINGLE), .WAIT_RST(32'h1)) uut_s (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(o_rv[2]),
        .resp_err(o_err[2]), .resp_rdata(o_rdata[2]), .cpu_release(o_rel[2]),
        .boot_vec0(o_v0[2]), .boot_vec1(o_v1[2]));

    // Compare one value
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One bus access; outputs captured one rising edge later
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            c_rdata[i] = o_rdata[i];
            c_err[i]   = o_err[i];
            c_rv[i]    = o_rv[i];
            c_rel[i]   = o_rel[i];
        end
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Read on all three and check data and error
    task automatic rd3(input string tag, input logic [11:0] a,
                       input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2,
                       input logic r0, input logic r1, input logic r2);
        access(1'b0, a, '0);
        check({tag, " basic data"},  c_rdata[0], e0);
        check({tag, " dual data"},   c_rdata[1], e1);
        check({tag, " single data"}, c_rdata[2], e2);
        check({tag, " basic err"},   32'(c_err[0]), 32'(r0));
        check({tag, " dual err"},    32'(c_err[1]), 32'(r1));
        check({tag, " single err"},  32'(c_err[2]), 32'(r2));
    endtask

    // Write on all three and check the error flags
    task automatic wr3(input string tag, input logic [11:0] a, input logic [31:0] d,
                       input logic r0, input logic r1, input logic r2);
        access(1'b1, a, d);
        check({tag, " basic err"},  32'(c_err[0]), 32'(r0));
        check({tag, " dual err"},   32'(c_err[1]), 32'(r1));
        check({tag, " single err"}, 32'(c_err[2]), 32'(r2));
    endtask

    // Release pulse values in the response cycle, then low one cycle later
    task automatic rel_chk(input string tag, input logic [1:0] e0, input logic [1:0] e1,
                           input logic [1:0] e2);
        check({tag, " basic rel"},  32'(c_rel[0]), 32'(e0));
        check({tag, " dual rel"},   32'(c_rel[1]), 32'(e1));
        check({tag, " single rel"}, 32'(c_rel[2]), 32'(e2));
        @(negedge clk);
        for (int i = 0; i < 3; i++) check({tag, " rel drop"}, 32'(o_rel[i]), 32'h0);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            check("R1 resp_valid idle", 32'(o_rv[i]), 32'h0);
            check("R1 release idle", 32'(o_rel[i]), 32'h0);
            check("R1 boot_vec0", o_v0[i], 32'h1000_0000);
        end
        check("R1 boot_vec1 dual", o_v1[1], 32'h0);
        rd3("R1 boot0", 12'h110, 32'h1000_0000, 32'h1000_0000, 32'h1000_0000, 0, 0, 0);
        rd3("R1 sys sense", 12'h200, 0, 32'h7F, 32'h7F, 1, 0, 0);
        rd3("R1 pwr", 12'h1FC, 0, 0, 32'h3, 1, 1, 0);
        rd3("R1 wait A", 12'h118, 0, 0, 0, 0, 0, 1);
        rd3("R1 wait B", 12'h120, 0, 0, 32'h1, 1, 1, 0);
        rd3("R1 nmi", 12'h11C, 0, 0, 0, 0, 0, 1);
        rd3("R1 boot1", 12'h114, 0, 0, 0, 1, 0, 1);
    endtask

    task automatic t_timing;
        access(1'b0, 12'h110, '0);
        for (int i = 0; i < 3; i++) check("R2 resp_valid in response cycle", 32'(c_rv[i]), 32'h1);
        @(negedge clk);
        for (int i = 0; i < 3; i++) check("R2 resp_valid drops", 32'(o_rv[i]), 32'h0);
        access(1'b1, 12'h000, 32'hFFFF_FFFF);
        for (int i = 0; i < 3; i++) begin
            check("R2 write resp_valid", 32'(c_rv[i]), 32'h1);
            check("R2 write data zero", c_rdata[i], 32'h0);
        end
    endtask

    task automatic t_id;
        logic [7:0] tbl [12];
        tbl = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8, 8'h1B, 8'h00,
                8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 12; k++) begin
            rd3("R5 id", 12'hFD0 + 12'(4 * k), (k == 6) ? 32'h0B : 32'(tbl[k]),
                32'(tbl[k]), 32'(tbl[k]), 0, 0, 0);
        end
    endtask

    task automatic t_boot;
        wr3("R6 boot0 write", 12'h110, 32'h2000_00FF, 0, 0, 0);
        check("R6 basic vec", o_v0[0], 32'h2000_00FF);
        check("R6 dual vec", o_v0[1], 32'h2000_00FF);
        check("R7 single vec masked", o_v0[2], 32'h2000_0080);
        rd3("R7 boot0 readback", 12'h110, 32'h2000_00FF, 32'h2000_00FF, 32'h2000_00FF, 0, 0, 0);
        wr3("R7 write when locked", 12'h110, 32'h3000_0000, 0, 0, 1);
        check("R6 basic vec 2", o_v0[0], 32'h3000_0000);
        check("R7 single vec held", o_v0[2], 32'h2000_0080);
        rd3("R7 boot0 after lock", 12'h110, 32'h3000_0000, 32'h3000_0000, 32'h2000_00FF, 0, 0, 0);
    endtask

    task automatic t_pwr;
        wr3("R8 pwr clear unlock", 12'h1FC, 32'h2, 1, 1, 0);
        rd3("R8 pwr readback", 12'h1FC, 0, 0, 32'h2, 1, 1, 0);
        wr3("R8 pwr write when locked", 12'h1FC, 32'h3, 1, 1, 1);
        rd3("R8 pwr unchanged", 12'h1FC, 0, 0, 32'h2, 1, 1, 0);
    endtask

    task automatic t_wait;
        wr3("R9 wait set", 12'h118, 32'h3, 0, 0, 1);
        rel_chk("R9 no release on set", 2'b00, 2'b00, 2'b00);
        wr3("R9 wait clr1", 12'h118, 32'h1, 0, 0, 1);
        rel_chk("R9 release cpu1", 2'b10, 2'b10, 2'b00);
        wr3("R9 wait clr0", 12'h118, 32'h0, 0, 0, 1);
        rel_chk("R9 release cpu0", 2'b01, 2'b01, 2'b00);
        wr3("R9 wait set again", 12'h118, 32'h3, 0, 0, 1);
        wr3("R9 wait clr both", 12'h118, 32'h0, 0, 0, 1);
        rel_chk("R9 release both", 2'b11, 2'b11, 2'b00);
        wr3("R10 single wait at 0x120", 12'h120, 32'h0, 1, 1, 0);
        rel_chk("R10 single release cpu0", 2'b00, 2'b00, 2'b01);
        wr3("R9 single set bit1", 12'h120, 32'h2, 1, 1, 0);
        wr3("R9 single clr bit1", 12'h120, 32'h0, 1, 1, 0);
        rel_chk("R9 single ignores cpu1", 2'b00, 2'b00, 2'b00);
        rd3("R10 single wait readback", 12'h120, 0, 0, 0, 1, 1, 0);
    endtask

    task automatic t_nmi;
        wr3("R4 write 0x11C", 12'h11C, 32'h5, 1, 0, 1);
        rd3("R4 read 0x11C", 12'h11C, 0, 32'h5, 0, 0, 0, 1);
        wr3("R10 write 0x124", 12'h124, 32'h7, 1, 0, 0);
        rd3("R11 read 0x124", 12'h124, 0, 32'h7, 32'h7, 1, 0, 0);
        rd3("R11 nmi separate from ewctl", 12'h11C, 0, 32'h5, 0, 0, 0, 1);
    endtask

    task automatic t_map;
        wr3("R11 boot1 write", 12'h114, 32'hABCD_0000, 1, 0, 1);
        check("R11 dual boot_vec1", o_v1[1], 32'hABCD_0000);
        check("R11 basic boot_vec1", o_v1[0], 32'h0);
        check("R11 single boot_vec1", o_v1[2], 32'h0);
        wr3("R10 sense x0 write", 12'h214, 32'h11, 1, 0, 0);
        wr3("R10 sense x1 write", 12'h218, 32'h22, 1, 0, 0);
        rd3("R10 sense x0", 12'h214, 0, 32'h11, 32'h11, 1, 0, 0);
        rd3("R10 sense x1", 12'h218, 0, 32'h22, 32'h22, 1, 0, 0);
        wr3("R11 sense m0 write", 12'h20C, 32'h33, 1, 0, 1);
        rd3("R11 sense m0", 12'h20C, 0, 32'h33, 0, 1, 0, 1);
        rd3("R10 sense m1", 12'h210, 0, 0, 0, 1, 0, 1);
        wr3("R10 cpu sense write", 12'h204, 32'h44, 1, 1, 0);
        rd3("R10 cpu sense", 12'h204, 0, 0, 32'h44, 1, 1, 0);
    endtask

    task automatic t_basic_gaps;
        for (int k = 0; k < 4; k++) begin
            wr3("R12 clock/security write", 12'(4 * k), 32'h5A + 32'(k), 1, 0, 0);
            rd3("R12 clock/security read", 12'(4 * k), 0, 32'h5A + 32'(k), 32'h5A + 32'(k), 1, 0, 0);
        end
    endtask

    task automatic t_invalid;
        rd3("R3 misaligned read", 12'h112, 0, 0, 0, 1, 1, 1);
        wr3("R3 misaligned write", 12'h111, 32'hDEAD_BEEF, 1, 1, 1);
        rd3("R3 boot0 untouched", 12'h110, 32'h3000_0000, 32'h3000_0000, 32'h2000_00FF, 0, 0, 0);
        rd3("R3 unmapped read", 12'h300, 0, 0, 0, 1, 1, 1);
        wr3("R3 unmapped write", 12'h300, 32'h1234, 1, 1, 1);
        wr3("R4 id write", 12'hFE0, 32'hFF, 1, 1, 1);
        rd3("R4 id unchanged", 12'hFE0, 32'h54, 32'h54, 32'h54, 0, 0, 0);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_id();
        t_boot();
        t_pwr();
        t_wait();
        t_nmi();
        t_map();
        t_basic_gaps();
        t_invalid();
        done = 1'b1;
        summary();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            summary();
        end
    end

endmodule